// File: doc/BRIEF.md
# Channel Gain Scaler with Rounding and Clipping

This block multiplies one channel of signed 16-bit complex baseband samples by a programmable gain just before that channel is merged with its neighbours. Both the in-phase and quadrature parts are multiplied by the same unsigned 8-bit gain code. The code is read as a fixed-point fraction with seven fractional bits, so the factor is the code divided by 128. Each scaled part is rounded back to 16 bits and clipped to the signed 16-bit range. A code of zero silences the channel, and the value after reset passes samples through unchanged.

Samples arrive with a single valid strobe and leave two clock cycles later with their own valid strobe. There is no backpressure. The gain is held in a register that a narrow write port loads. Each instance answers one write address, set by a parameter, so four instances placed at consecutive addresses give four independent channel gains.

Top module: `chan_gain_scaler`

## Requirements
- R1: Each output part equals the matching input part times the gain code divided by 128. I and Q are computed separately with the same code.
- R2: Rounding adds 64 to the full product and then shifts right arithmetically by 7. A product exactly halfway between two integers rounds toward plus infinity, so product 64 gives 1 and product -64 gives 0.
- R3: A rounded value above 32767 is output as 0x7FFF. A rounded value below -32768 is output as 0x8000.
- R4: A gain code of 0 gives 0 on both output parts for every input.
- R5: After reset the gain code is 0x80, out_valid is 0 and both output parts are 0.
- R6: A write with wr_en high loads wr_data into the gain register only when wr_addr equals the GAIN_ADDR parameter (default 0x25). A write to any other address leaves the gain unchanged.
- R7: A sample presented in the same cycle as a gain write uses the old gain. A sample presented in any later cycle uses the new gain.
- R8: out_valid is high exactly two cycles after a cycle with in_valid high, and low at every other time.
- R9: With gain code 0x80, every sample comes out unchanged, including -32768 and 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Gain register write strobe |
| wr_addr | input | 8 | Write address, matched against GAIN_ADDR |
| wr_data | input | 8 | New gain code |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Input in-phase part, two's complement |
| in_q | input | 16 | Input quadrature part, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Scaled in-phase part |
| out_q | output | 16 | Scaled quadrature part |

## Verification
The bench uses the default build: 16-bit samples, an 8-bit gain with seven fractional bits, and write address 0x25. With these values the bench can sweep all 256 gain codes. Under each code it streams the full-scale extremes, the samples whose products land on the rounding halfway points, and a spread of other values. This covers muting, unity gain, clipping at both ends and the round-half-up rule. Separate short sequences check the following:
- writes to another address;
- a write in the same cycle as a sample;
- gaps in the input stream.

// File: rtl/gain_scaler_pkg.sv
package gain_scaler_pkg;

    localparam int SAMPLE_W = 16;
    localparam int GAIN_W   = 8;
    localparam int FRAC_W   = 7;
    localparam int LANES    = 2;
    localparam int PROD_W   = SAMPLE_W + GAIN_W + 1;
    localparam int BIAS_W   = PROD_W + 1;
    localparam int RS_W     = BIAS_W - FRAC_W;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic [GAIN_W-1:0]          gain_t;
    typedef logic signed [PROD_W-1:0]   prod_t;
    typedef sample_t [LANES-1:0]        iq_t;
    typedef prod_t   [LANES-1:0]        iq_prod_t;

    typedef enum logic [1:0] {
        CLIP_NONE = 2'd0,
        CLIP_HIGH = 2'd1,
        CLIP_LOW  = 2'd2
    } clip_e;

    localparam gain_t   GAIN_UNITY = gain_t'(1 << FRAC_W);
    localparam sample_t SAT_POS    = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam sample_t SAT_NEG    = {1'b1, {(SAMPLE_W-1){1'b0}}};

    function automatic logic signed [RS_W-1:0] round_prod(input prod_t p);
        logic signed [BIAS_W-1:0] biased;
        biased = BIAS_W'(p) + BIAS_W'(1 << (FRAC_W - 1));
        return biased[BIAS_W-1:FRAC_W];
    endfunction

    function automatic clip_e classify(input logic signed [RS_W-1:0] r);
        if (r > $signed({{(RS_W-SAMPLE_W){1'b0}}, SAT_POS}))
            return CLIP_HIGH;
        else if (r < $signed({{(RS_W-SAMPLE_W){1'b1}}, SAT_NEG}))
            return CLIP_LOW;
        else
            return CLIP_NONE;
    endfunction

endpackage

// File: rtl/gs_gain_reg.sv
module gs_gain_reg
    import gain_scaler_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] GAIN_ADDR = ADDR_W'(8'h25)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  gain_t             wr_data,
    output gain_t             gain_o
);

    logic hit;

    assign hit = wr_en && (wr_addr == GAIN_ADDR);

    always_ff @(posedge clk) begin
        if (rst)
            gain_o <= GAIN_UNITY;
        else if (hit)
            gain_o <= wr_data;
    end

endmodule

// File: rtl/gs_mult.sv
module gs_mult
    import gain_scaler_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  iq_t      in_iq,
    input  gain_t    gain,
    output logic     p_valid,
    output iq_prod_t p_iq
);

    prod_t gain_ext;

    assign gain_ext = prod_t'($signed({1'b0, gain}));

    always_ff @(posedge clk) begin
        if (rst)
            p_valid <= 1'b0;
        else
            p_valid <= in_valid;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        prod_t prod_d;
        assign prod_d = prod_t'(in_iq[l]) * gain_ext;

        always_ff @(posedge clk) begin
            if (rst)
                p_iq[l] <= '0;
            else if (in_valid)
                p_iq[l] <= prod_d;
        end
    end

endmodule

// File: rtl/gs_round_sat.sv
module gs_round_sat
    import gain_scaler_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     p_valid,
    input  iq_prod_t p_iq,
    output logic     out_valid,
    output iq_t      out_iq
);

    always_ff @(posedge clk) begin
        if (rst)
            out_valid <= 1'b0;
        else
            out_valid <= p_valid;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic signed [RS_W-1:0] rounded;
        clip_e                  kind;
        sample_t                res;

        assign rounded = round_prod(p_iq[l]);
        assign kind    = classify(rounded);

        always_comb begin
            unique case (kind)
                CLIP_HIGH: res = SAT_POS;
                CLIP_LOW:  res = SAT_NEG;
                default:   res = rounded[SAMPLE_W-1:0];
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst)
                out_iq[l] <= '0;
            else if (p_valid)
                out_iq[l] <= res;
        end
    end

endmodule

// File: rtl/chan_gain_scaler.sv
module chan_gain_scaler
    import gain_scaler_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] GAIN_ADDR = ADDR_W'(8'h25)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [GAIN_W-1:0]          wr_data,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_i,
    input  logic signed [SAMPLE_W-1:0] in_q,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_i,
    output logic signed [SAMPLE_W-1:0] out_q
);

    gain_t    gain_q;
    iq_t      in_iq;
    iq_t      out_iq;
    iq_prod_t p_iq;
    logic     p_valid;

    assign in_iq[0] = in_i;
    assign in_iq[1] = in_q;
    assign out_i    = out_iq[0];
    assign out_q    = out_iq[1];

    gs_gain_reg #(
        .ADDR_W    (ADDR_W),
        .GAIN_ADDR (GAIN_ADDR)
    ) u_gain (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .gain_o  (gain_q)
    );

    gs_mult u_mult (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_iq    (in_iq),
        .gain     (gain_q),
        .p_valid  (p_valid),
        .p_iq     (p_iq)
    );

    gs_round_sat u_rs (
        .clk       (clk),
        .rst       (rst),
        .p_valid   (p_valid),
        .p_iq      (p_iq),
        .out_valid (out_valid),
        .out_iq    (out_iq)
    );

endmodule

// File: rtl/chan_gain_scaler_chk.sv
module chan_gain_scaler_chk
    import gain_scaler_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] GAIN_ADDR = ADDR_W'(8'h25)
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [GAIN_W-1:0]          wr_data,
    input logic [GAIN_W-1:0]          gain_q,
    input logic                       in_valid,
    input logic signed [SAMPLE_W-1:0] in_i,
    input logic signed [SAMPLE_W-1:0] in_q,
    input logic                       out_valid,
    input logic signed [SAMPLE_W-1:0] out_i,
    input logic signed [SAMPLE_W-1:0] out_q
);

    logic    v1, v2, m1, m2, u1, u2;
    sample_t di1, di2, dq1, dq2;

    always_ff @(posedge clk) begin
        if (rst) begin
            {v1, v2, m1, m2, u1, u2} <= '0;
            {di1, di2, dq1, dq2}     <= '0;
        end else begin
            v1  <= in_valid;
            v2  <= v1;
            m1  <= in_valid && (gain_q == '0);
            m2  <= m1;
            u1  <= in_valid && (gain_q == GAIN_UNITY);
            u2  <= u1;
            di1 <= in_i;
            di2 <= di1;
            dq1 <= in_q;
            dq2 <= dq1;
        end
    end

    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid == v2);

    p_mute_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && m2) |-> (out_i == '0 && out_q == '0));

    p_unity_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && u2) |-> (out_i == di2 && out_q == dq2));

    p_reset_gain_r5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (gain_q == GAIN_UNITY && !out_valid));

    p_write_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == GAIN_ADDR) |=> (gain_q == $past(wr_data)));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == GAIN_ADDR) |=> $stable(gain_q));

endmodule

bind chan_gain_scaler chan_gain_scaler_chk #(
    .ADDR_W    (ADDR_W),
    .GAIN_ADDR (GAIN_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .gain_q    (gain_q),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/chan_gain_scaler_test.sv
module chan_gain_scaler_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] ADDR = 8'h25;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              in_valid = 1'b0;
    logic signed [15:0] in_i = '0;
    logic signed [15:0] in_q = '0;
    logic              out_valid;
    logic signed [15:0] out_i;
    logic signed [15:0] out_q;

    int checks = 0;
    int fails  = 0;
    int gain_m = 128;
    bit done   = 1'b0;

    bit    pe1_v = 0, pe2_v = 0;
    int    pe1_i = 0, pe1_q = 0, pe2_i = 0, pe2_q = 0;
    string pe1_t = "", pe2_t = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_gain_scaler #(.ADDR_W(8), .GAIN_ADDR(ADDR)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    function automatic int model(input int s, input int g, output bit clip);
        int p, r;
        p = s * g;
        r = (p + 64) >>> 7;
        clip = 1'b0;
        if (r > 32767) begin r = 32767; clip = 1'b1; end
        if (r < -32768) begin r = -32768; clip = 1'b1; end
        return r;
    endfunction

    task automatic step(input bit v, input int si, input int sq,
                        input bit we, input logic [7:0] wa, input logic [7:0] wd,
                        input string tag);
        bit ci, cq;
        int ei, eq;
        string t;
        @(negedge clk);
        checks++;
        if (pe2_v) begin
            if (out_valid !== 1'b1 || int'(out_i) != pe2_i || int'(out_q) != pe2_q) begin
                fails++;
                $display("FAIL %s: valid=%0b i=%0d q=%0d expected valid=1 i=%0d q=%0d",
                         pe2_t, out_valid, out_i, out_q, pe2_i, pe2_q);
            end
        end else if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R8: out_valid=%0b expected 0", out_valid);
        end
        ei = model(si, gain_m, ci);
        eq = model(sq, gain_m, cq);
        if (tag != "") t = tag;
        else if (gain_m == 0) t = "R4";
        else if (gain_m == 128) t = "R9";
        else if (ci || cq) t = "R3";
        else t = "R1";
        pe2_v = pe1_v; pe2_i = pe1_i; pe2_q = pe1_q; pe2_t = pe1_t;
        pe1_v = v;     pe1_i = ei;    pe1_q = eq;    pe1_t = t;
        if (we && wa == ADDR) gain_m = int'(wd);
        in_valid = v;
        in_i     = 16'(si);
        in_q     = 16'(sq);
        wr_en    = we;
        wr_addr  = wa;
        wr_data  = wd;
    endtask

    task automatic idle();
        step(1'b0, 0, 0, 1'b0, 8'h00, 8'h00, "");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int edges [14] = '{-32768, -32767, -65, -64, -63, -1, 0, 1, 63, 64, 65, 32766, 32767, 255};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R5: reset state at the ports
        checks++;
        if (out_valid !== 1'b0 || out_i !== 16'sd0 || out_q !== 16'sd0) begin
            fails++;
            $display("FAIL R5: valid=%0b i=%0d q=%0d expected 0 0 0", out_valid, out_i, out_q);
        end
        // R5 / R9: default gain is unity
        foreach (edges[k]) step(1'b1, edges[k], -edges[k] - 1, 1'b0, 0, 0, "R5");
        // R6: write to another address is ignored
        step(1'b0, 0, 0, 1'b1, 8'h26, 8'h00, "");
        step(1'b0, 0, 0, 1'b1, 8'h24, 8'h03, "");
        step(1'b1, 1000, -1000, 1'b0, 0, 0, "R6");
        // R7: sample in the write cycle uses the old gain, next one the new gain
        step(1'b1, 20000, -20000, 1'b1, ADDR, 8'h40, "R7");
        step(1'b1, 20000, -20000, 1'b0, 0, 0, "R7");
        // R8: gaps in the stream
        idle();
        step(1'b1, 300, 301, 1'b0, 0, 0, "R8");
        idle();
        idle();
        step(1'b1, -300, 7, 1'b0, 0, 0, "R8");
        // R2: halfway points with gain code 1
        step(1'b0, 0, 0, 1'b1, ADDR, 8'h01, "");
        step(1'b1, 64, -64, 1'b0, 0, 0, "R2");
        step(1'b1, -65, 192, 1'b0, 0, 0, "R2");
        step(1'b1, -192, 63, 1'b0, 0, 0, "R2");
        // R1, R3, R4, R9: sweep of every gain code
        for (int g = 0; g < 256; g++) begin
            step(1'b0, 0, 0, 1'b1, ADDR, 8'(g), "");
            foreach (edges[k]) step(1'b1, edges[k], edges[13 - k], 1'b0, 0, 0, "");
            for (int n = 0; n < 20; n++) begin
                int a, b;
                a = ((n * 7919 + g * 31) % 65536) - 32768;
                b = ((n * 3571 + g * 977 + 12345) % 65536) - 32768;
                step(1'b1, a, b, 1'b0, 0, 0, "");
            end
        end
        idle();
        idle();
        idle();
        finish_run();
    end

endmodule